// File: doc/BRIEF.md
# Variable-Length Bytecode Prefetch Queue

This block is the instruction-fetch front end for a byte-oriented stack-machine instruction set. Each instruction is a one-byte opcode followed by zero to four operand bytes, so an instruction is one to five bytes long. The block reads aligned 32-bit words from instruction memory into a small byte queue. It finds the length of the instruction at the head of the queue from its opcode. Once every byte of that instruction is held, it presents the whole instruction to the decode stage as a single packet.

Memory is read through a request port with a fixed latency of one cycle. The word for a request raised in cycle t is sampled in cycle t+1. A fetch is issued only when the queue still has room for a full word, counting a word that is already on its way. A taken jump drives `flush` with the new byte address. This empties the queue in one cycle and restarts fetching from the word that holds that address. Any leading bytes of that first word that lie before the target are dropped. Decode accepts packets through a valid/ready handshake.

Top module: `byte_prefetch_queue`

## Requirements
- R1: After reset the block presents no packet (`out_valid` low), and it requests the word at byte address 0 in the first cycle after reset.
- R2: Every fetch address is word-aligned (bits 1:0 zero). The word for a request is taken from `fetch_rdata` in the next cycle. Bits [8k+7:8k] of that word hold the byte at address `fetch_addr`+k.
- R3: The queue never holds more than QBYTES bytes. While decode stalls with the queue full, `fetch_req` stays low.
- R4: Opcode lengths are as follows. Opcodes 0x10, 0x15–0x19 and 0x36–0x3A take 2 bytes. Opcodes 0x11, 0x84, 0x99–0xA8 and 0xB2–0xB8 take 3 bytes. Opcode 0xC5 takes 4 bytes. Opcodes 0xB9 and 0xC8 take 5 bytes.
- R5: `out_valid` is high only when the queue holds every byte of the head instruction. The packet carries the opcode in `out_opc`, the length in `out_len` and the opcode's byte address in `out_pc`. The first operand byte is in `out_opnd[7:0]`, the next in [15:8], and so on. Unused operand bytes are zero.
- R6: While `out_valid` is high, `out_ready` is low and no flush occurs, the packet stays unchanged into the next cycle.
- R7: When a packet is accepted (valid and ready with no flush), the next packet's `out_pc` is the accepted `out_pc` plus the accepted `out_len`.
- R8: A cycle with `flush` high accepts no packet and empties the queue, so `out_valid` is low in the next cycle. The next packet delivered starts at `flush_pc`. Bytes of the first fetched word below `flush_pc` are discarded, and a word arriving in the flush cycle is dropped.
- R9: Every opcode not listed in R4 (for example 0x00, 0x60, 0xFF) is treated as a 1-byte instruction and is passed to decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | output | 1 | Word read request |
| fetch_addr | output | PC_W | Word-aligned byte address of the request |
| fetch_rdata | input | 32 | Word returned one cycle after the request |
| flush | input | 1 | Discard the queue and restart at `flush_pc` |
| flush_pc | input | PC_W | Byte address of the new instruction stream |
| out_valid | output | 1 | A complete instruction is presented |
| out_ready | input | 1 | Decode accepts the packet |
| out_opc | output | 8 | Opcode byte |
| out_opnd | output | 32 | Operand bytes, first operand in the low byte |
| out_len | output | 3 | Instruction length in bytes, 1 to 5 |
| out_pc | output | PC_W | Byte address of the opcode |

## Verification
The bench builds the block with QBYTES=8 and PC_W=16, and backs it with a 256-byte program image filled with mixed-length instructions. With only eight bytes of storage, a stall fills the queue after two words. This makes the fetch credit limit reachable within a few cycles. Five-byte instructions that straddle two words then exercise the wait for the second word. Flushes to unaligned targets, flushes while a packet is being accepted, and runs with ready held low or toggling cover the discard of leading bytes, flush priority and packet hold.

// File: rtl/byte_prefetch_queue.sv
module byte_prefetch_queue #(
  parameter int QBYTES = 8,
  parameter int PC_W   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            fetch_req,
  output logic [PC_W-1:0] fetch_addr,
  input  logic [31:0]     fetch_rdata,
  input  logic            flush,
  input  logic [PC_W-1:0] flush_pc,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [7:0]      out_opc,
  output logic [31:0]     out_opnd,
  output logic [2:0]      out_len,
  output logic [PC_W-1:0] out_pc
);
  localparam int CW = $clog2(QBYTES + 1);
  localparam int IW = $clog2(QBYTES);

  logic [7:0]      q  [QBYTES];
  logic [7:0]      nq [QBYTES];
  logic [7:0]      wb [4];
  logic [CW-1:0]   count, count_n;
  logic [PC_W-1:0] pc_r, faddr;
  logic            inflight, pop;
  logic [1:0]      skip;

  function automatic logic [2:0] opc_len(input logic [7:0] o);
    if (o == 8'h10 || (o >= 8'h15 && o <= 8'h19) || (o >= 8'h36 && o <= 8'h3A)) return 3'd2;
    if (o == 8'h11 || o == 8'h84 || (o >= 8'h99 && o <= 8'hA8) || (o >= 8'hB2 && o <= 8'hB8)) return 3'd3;
    if (o == 8'hC5) return 3'd4;
    if (o == 8'hB9 || o == 8'hC8) return 3'd5;
    return 3'd1;
  endfunction

  assign out_opc    = q[0];
  assign out_len    = opc_len(q[0]);
  assign out_valid  = int'(out_len) <= int'(count);
  assign out_pc     = pc_r;
  assign fetch_addr = faddr;
  assign fetch_req  = !flush && (int'(count) + (inflight ? 4 : 0) + 4 <= QBYTES);
  assign pop        = out_valid && out_ready && !flush;

  for (genvar k = 0; k < 4; k++) begin : g_lanes
    assign out_opnd[8*k +: 8] = (k + 1 < int'(out_len)) ? q[k+1] : 8'h00;
    assign wb[k] = fetch_rdata[8*k +: 8];
  end

  always_comb begin
    int plen, keep, nin;
    plen = pop ? int'(out_len) : 0;
    keep = int'(count) - plen;
    nin  = inflight ? 4 - int'(skip) : 0;
    for (int i = 0; i < QBYTES; i++) begin
      int idx, sel;
      idx   = i + plen;
      sel   = i - keep + int'(skip);
      nq[i] = 8'h00;
      if (idx < int'(count))
        nq[i] = q[idx[IW-1:0]];
      else if (i >= keep && i - keep < nin)
        nq[i] = wb[sel[1:0]];
    end
    count_n = CW'(keep + nin);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      pc_r     <= '0;
      faddr    <= '0;
      inflight <= 1'b0;
      skip     <= 2'd0;
      for (int i = 0; i < QBYTES; i++) q[i] <= 8'h00;
    end else begin
      inflight <= fetch_req;
      if (flush) begin
        count <= '0;
        pc_r  <= flush_pc;
        faddr <= {flush_pc[PC_W-1:2], 2'b00};
        skip  <= flush_pc[1:0];
      end else begin
        q     <= nq;
        count <= count_n;
        if (pop)       pc_r  <= pc_r + PC_W'(out_len);
        if (fetch_req) faddr <= faddr + PC_W'(4);
        if (inflight)  skip  <= 2'd0;
      end
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= QBYTES);
  // R2
  aligned_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> fetch_addr[1:0] == 2'b00);
  // R6
  hold_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_opc) && $stable(out_opnd) && $stable(out_pc));
  // R7
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !flush |=> out_pc == $past(out_pc) + PC_W'($past(out_len)));
  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid && out_pc == $past(flush_pc));
endmodule

// File: tb/tb_byte_prefetch_queue.sv
`timescale 1ns/1ps
module tb_byte_prefetch_queue;
  localparam int QB = 8;
  localparam int PW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch_req, flush = 1'b0, out_valid, out_ready = 1'b0;
  logic [PW-1:0] fetch_addr, flush_pc = '0, out_pc;
  logic [31:0] fetch_rdata = '0, out_opnd;
  logic [7:0] out_opc;
  logic [2:0] out_len;

  always #2.5 clk = ~clk;

  byte_prefetch_queue #(.QBYTES(QB), .PC_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_rdata(fetch_rdata), .flush(flush), .flush_pc(flush_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_opc(out_opc),
    .out_opnd(out_opnd), .out_len(out_len), .out_pc(out_pc));

  logic [7:0] mem [256];
  logic [7:0] pool [16] = '{8'h00, 8'h10, 8'h15, 8'h3A, 8'h11, 8'h84, 8'h99, 8'hA8,
                            8'hB2, 8'hC5, 8'hB9, 8'hC8, 8'hFF, 8'h60, 8'h36, 8'hB8};
  int starts[$];
  logic [58:0] expq[$];
  int checks = 0, errors = 0, npk = 0;
  bit done = 1'b0;
  logic [7:0] lf = 8'h5A;

  function automatic int ref_len(input logic [7:0] o);
    if (o inside {8'hB9, 8'hC8}) return 5;
    if (o == 8'hC5) return 4;
    if (o inside {8'h11, 8'h84, [8'h99:8'hA8], [8'hB2:8'hB8]}) return 3;
    if (o inside {8'h10, [8'h15:8'h19], [8'h36:8'h3A]}) return 2;
    return 1;
  endfunction

  function automatic logic [31:0] word_at(input logic [7:0] a);
    return {mem[a + 8'd3], mem[a + 8'd2], mem[a + 8'd1], mem[a]};
  endfunction

  function automatic logic [58:0] exp_pkt(input int a);
    logic [7:0] o;
    logic [31:0] opnd;
    int l;
    o = mem[a[7:0]];
    l = ref_len(o);
    opnd = '0;
    for (int j = 1; j < l; j++) opnd[8*(j-1) +: 8] = mem[8'(a + j)];
    return {16'(a), 3'(l), opnd, o};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_from(input int a);
    bit on = 1'b0;
    expq.delete();
    foreach (starts[s]) begin
      if (starts[s] == a) on = 1'b1;
      if (on) expq.push_back(exp_pkt(starts[s]));
    end
  endtask

  // memory model, one cycle latency (R2)
  always @(posedge clk) fetch_rdata <= fetch_req ? word_at(fetch_addr[7:0]) : 32'h0;

  // scoreboard monitor
  logic hold_prev = 1'b0;
  logic [58:0] hold_pkt;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [58:0] got, e;
      got = {out_pc, out_len, out_opnd, out_opc};
      if (hold_prev)
        check(out_valid && got == hold_pkt, "R6 packet hold under stall", {4'h0, out_valid, got}, {5'h1, hold_pkt});
      hold_prev = out_valid && !out_ready && !flush;
      hold_pkt  = got;
      if (out_valid && out_ready && !flush && expq.size() > 0) begin
        e = expq.pop_front();
        npk++;
        if (ref_len(e[7:0]) == 1 && !(e[7:0] inside {8'h00, 8'h60, 8'hFF}))
          check(got == e, "R4 R5 packet", {5'h0, got}, {5'h0, e});
        else if (e[7:0] inside {8'h00, 8'h60, 8'hFF})
          check(got == e, "R9 unknown opcode packet", {5'h0, got}, {5'h0, e});
        else
          check(got == e, "R2 R4 R5 R7 packet", {5'h0, got}, {5'h0, e});
      end
    end
  end

  task automatic run(input int n, input int mode);
    repeat (n) begin
      @(posedge clk); #1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      case (mode)
        0: out_ready = 1'b1;
        1: out_ready = lf[0] | lf[2];
        default: out_ready = 1'b0;
      endcase
    end
  endtask

  task automatic do_flush(input int a);
    @(posedge clk); #1;
    flush = 1'b1;
    flush_pc = PW'(a);
    push_from(a);
    @(posedge clk); #1;
    flush = 1'b0;
    @(negedge clk);
    check(!out_valid, "R8 queue empty after flush", {63'h0, out_valid}, 64'h0);
  endtask

  function automatic int pick(input int from, input int lane, input int want_len);
    for (int s = from; s < starts.size(); s++)
      if (starts[s] % 4 == lane && (want_len == 0 || ref_len(mem[starts[s]]) == want_len))
        return starts[s];
    return starts[from];
  endfunction

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired R5 actual=hang expected=finish");
      report();
      $finish;
    end
  end

  initial begin
    int pos, k, base;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    pos = 0;
    k = 0;
    while (pos < 235) begin
      logic [7:0] o;
      o = pool[(k * 7 + 3) % 16];
      mem[pos] = o;
      for (int j = 1; j < ref_len(o); j++) mem[pos + j] = 8'((pos * 13 + j * 29 + 7) & 255);
      starts.push_back(pos);
      pos += ref_len(o);
      k++;
    end
    push_from(0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R1 no packet after reset", {63'h0, out_valid}, 64'h0);
    check(fetch_req && fetch_addr == 0, "R1 first fetch at address 0", {47'h0, fetch_req, fetch_addr}, {47'h0, 1'b1, 16'h0});

    base = npk;
    run(120, 0);
    check(npk - base > 10, "R5 packets flow with ready high", 64'(npk - base), 64'd11);

    do_flush(pick(3, 3, 0));
    base = npk;
    run(150, 1);
    check(npk - base > 5, "R8 packets after unaligned flush", 64'(npk - base), 64'd6);

    do_flush(pick(10, 0, 0));
    run(20, 2);
    @(negedge clk);
    check(!fetch_req, "R3 fetch held off while queue full", {63'h0, fetch_req}, 64'h0);
    check(out_valid, "R5 head complete during stall", {63'h0, out_valid}, 64'h1);
    run(100, 1);

    run(6, 0);
    do_flush(pick(20, 2, 0));
    run(80, 0);

    do_flush(pick(5, 3, 5));
    base = npk;
    run(40, 1);
    check(npk - base > 2, "R2 R4 straddling five-byte target", 64'(npk - base), 64'd3);

    do_flush(pick(30, 1, 0));
    run(60, 2);
    run(120, 1);

    done = 1'b1;
    report();
    $finish;
  end
endmodule